// File: doc/BRIEF.md
# Staggered Frequency Word Load Sequencer

This block decides when a new frequency control word may enter a pipelined phase accumulator whose word is split into narrow slices. Each pipeline column takes its slice of the word one clock after the column before it. The block watches the incoming word and keeps a reference copy of it. When the word differs from that copy and no load is running, the block fires one load strobe per clock, walking from the lowest slice to the highest. The accumulator uses each strobe to take in its own slice.

A separate open flag is high only while every slice strobe is low. The input capture stage may take new word bits only while this flag is high. While a walk is running, the reference copy is frozen, so a word change cannot restart or disturb the walk. Once the walk ends and the flag is high again, the block compares the input with the word captured at the start of the last walk. If they differ, a fresh walk begins.

All strobes are ordinary synchronous signals. No clock-gating cell is instantiated.

Top module: `fcw_load_sequencer`

## Requirements
- R1: Reset is synchronous and active low. While it is held, every slice strobe is cleared and the reference copy takes the present input. After release, an unchanged input starts no walk and the open flag reads 1.
- R2: While the open flag is high and the input equals the reference copy, no slice strobe rises and the open flag stays high.
- R3: While the open flag is high, an input that differs from the reference copy makes `sliceLoad[0]` rise on the next clock edge. `sliceLoad[0]` strobes the lowest slice, bits [3:0].
- R4: Once `sliceLoad[i]` is high for one cycle, `sliceLoad[i+1]` is high in the following cycle. Each strobe stays high for exactly one cycle, so a walk covers the eight slices in eight consecutive cycles, lowest bits first.
- R5: At most one slice strobe is high in any cycle.
- R6: The open flag is the NOR of all slice strobes. It is low for exactly eight consecutive cycles per walk and goes high in the cycle after `sliceLoad[7]`.
- R7: Input changes while the open flag is low are ignored. No walk restarts, and the running walk continues unchanged.
- R8: The reference copy takes the input only while the open flag is high. After a walk ends, a new walk starts on the following edge only if the input then differs from the word captured when the previous walk began. An input that returned to that word before the walk ended starts no walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| wordIn | input | 32 | Incoming frequency control word |
| sliceLoad | output | 8 | One-hot slice load strobes; bit 0 is the lowest slice |
| loadOpen | output | 1 | High when no walk is in progress; new input words are accepted |

## Verification
The assertions check four things on every cycle. At most one strobe may be high. The open flag must match the state of the strobes. Each strobe must hand over to the next one. No walk may start while the open flag is low. They also check that a fresh change seen while the flag is open starts a walk, and that an unchanged word leaves the flag open.

Two behaviours depend on the history of the input across a whole walk, and only the bench scenarios show them. The first is that a walk is triggered by the frozen word captured at its start. The second is that a change which reverts before the walk ends is dropped. The bench also shows that reset leaves no walk pending.

// File: rtl/fcw_load_pkg.sv
package fcw_load_pkg;

  // Strobes from the control section to the datapath section.
  typedef struct packed {
    logic refLoad;   // reference copy follows the input this cycle
  } loadStrobe_t;

endpackage

// File: rtl/fcw_load_datapath.sv
module fcw_load_datapath
  import fcw_load_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 8,
  localparam int WORD_W = SLICE_W * SLICES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  loadStrobe_t       strobe,
  output logic              wordChanged
);

  logic [WORD_W-1:0] refWord;
  logic [SLICES-1:0] sliceDiff;

  // Reference copy: follows the input while loads are open, frozen otherwise.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refWord <= wordIn;
    end else if (strobe.refLoad) begin
      refWord <= wordIn;
    end
  end

  // Per-slice comparison, then a reduction across the slices.
  for (genvar s = 0; s < SLICES; s++) begin : g_sliceCmp
    assign sliceDiff[s] =
      (wordIn[s*SLICE_W +: SLICE_W] != refWord[s*SLICE_W +: SLICE_W]);
  end

  assign wordChanged = |sliceDiff;

endmodule

// File: rtl/fcw_load_control.sv
module fcw_load_control
  import fcw_load_pkg::*;
#(
  parameter int SLICES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordChanged,
  output logic [SLICES-1:0] sliceLoad,
  output logic              loadOpen,
  output loadStrobe_t       strobe
);

  logic [SLICES-1:0] walkReg;
  logic [SLICES-1:0] walkNext;
  logic              startWalk;

  assign loadOpen  = ~(|walkReg);
  assign startWalk = loadOpen & wordChanged;

  // The token enters at slice 0 and moves up one position per clock.
  assign walkNext[0] = startWalk;
  for (genvar s = 1; s < SLICES; s++) begin : g_shift
    assign walkNext[s] = walkReg[s-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkReg <= '0;
    end else begin
      walkReg <= walkNext;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.refLoad = loadOpen;
  end

  assign sliceLoad = walkReg;

endmodule

// File: rtl/fcw_load_sequencer.sv
module fcw_load_sequencer
  import fcw_load_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 8,
  localparam int WORD_W = SLICE_W * SLICES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  output logic [SLICES-1:0] sliceLoad,
  output logic              loadOpen
);

  loadStrobe_t strobe;
  logic        wordChanged;

  fcw_load_datapath #(
    .SLICE_W(SLICE_W),
    .SLICES (SLICES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .wordIn     (wordIn),
    .strobe     (strobe),
    .wordChanged(wordChanged)
  );

  fcw_load_control #(
    .SLICES(SLICES)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .wordChanged(wordChanged),
    .sliceLoad  (sliceLoad),
    .loadOpen   (loadOpen),
    .strobe     (strobe)
  );

endmodule

// File: rtl/fcw_load_sequencer_checker.sv
module fcw_load_sequencer_checker #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 8,
  localparam int WORD_W = SLICE_W * SLICES
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] wordIn,
  input logic [SLICES-1:0] sliceLoad,
  input logic              loadOpen
);

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sliceLoad));

  assert_open_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadOpen |-> ($countones(sliceLoad) == 0));

  assert_open_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    !loadOpen |-> ($countones(sliceLoad) == 1));

  assert_reopen_R6: assert property (@(posedge clk) disable iff (!rstN)
    sliceLoad[SLICES-1] |=> loadOpen);

  for (genvar s = 0; s < SLICES - 1; s++) begin : g_handover
    assert_handover_R4: assert property (@(posedge clk) disable iff (!rstN)
      sliceLoad[s] |=> (sliceLoad[s+1] && !sliceLoad[s]));
  end

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loadOpen |=> !sliceLoad[0]);

  assert_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadOpen && $past(loadOpen) && $past(rstN) && (wordIn != $past(wordIn)))
      |=> sliceLoad[0]);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loadOpen && $past(loadOpen) && $past(rstN) && (wordIn == $past(wordIn)))
      |=> loadOpen);

endmodule

bind fcw_load_sequencer fcw_load_sequencer_checker #(
  .SLICE_W(SLICE_W),
  .SLICES (SLICES)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .wordIn   (wordIn),
  .sliceLoad(sliceLoad),
  .loadOpen (loadOpen)
);

// File: tb/fcw_load_sequencer_bench.sv
module fcw_load_sequencer_bench;

  localparam int SLICES = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wordIn = 32'h1234_5678;
  logic [7:0]  sliceLoad;
  logic        loadOpen;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit primed = 0;

  logic [31:0] mRef;
  logic [7:0]  expLoad = '0;
  int          lowRun = 0;

  always #2 clk = ~clk;

  fcw_load_sequencer u_fcw_load_sequencer (
    .clk      (clk),
    .rstN     (rstN),
    .wordIn   (wordIn),
    .sliceLoad(sliceLoad),
    .loadOpen (loadOpen)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected strobes for the next edge, derived from the requirements.
  function automatic logic [7:0] nextLoad(input logic [7:0] cur, input bit changed);
    if (cur == 8'h00) return changed ? 8'h01 : 8'h00;
    return cur << 1;
  endfunction

  // One cycle: check the outputs, drive the next word, advance the model.
  task automatic step(input logic [31:0] w, input string tag);
    @(negedge clk);
    if (primed && rstN) begin
      check(sliceLoad == expLoad, tag, {24'h0, sliceLoad}, {24'h0, expLoad});
      check(loadOpen == (expLoad == 8'h00), tag, {31'h0, loadOpen},
            {31'h0, (expLoad == 8'h00)});
      check($countones(sliceLoad) <= 1, "R5", {24'h0, sliceLoad}, 32'h1);
      if (loadOpen) begin
        if (lowRun != 0)
          check(lowRun == SLICES, "R6", lowRun, SLICES);
        lowRun = 0;
      end else begin
        lowRun++;
      end
    end
    primed = 1;
    wordIn = w;
    if (!rstN) begin
      mRef = w;
      expLoad = 8'h00;
    end else if (expLoad == 8'h00) begin
      expLoad = nextLoad(expLoad, w != mRef);
      mRef = w;
    end else begin
      expLoad = nextLoad(expLoad, 1'b0);
    end
  endtask

  initial begin
    logic [31:0] cur;
    logic [31:0] capA;
    void'($urandom(32'd20240611));

    // R1: reset, then an unchanged word starts nothing
    cur = 32'h1234_5678;
    for (int i = 0; i < 3; i++) step(cur, "R1");
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 4; i++) step(cur, "R1");

    // R2: word held steady
    for (int i = 0; i < 5; i++) step(cur, "R2");

    // R3 then R4: one change, full walk, lowest slice first
    cur = 32'h8765_4321;
    step(cur, "R3");
    for (int i = 0; i < 10; i++) step(cur, "R4");

    // R7: word churns during the window, no restart
    capA = 32'h0F0F_0F0F;
    step(capA, "R3");
    for (int i = 0; i < 7; i++) step(32'hA000_0000 + i, "R7");
    // R8: final word differs from the captured one, so a new walk follows
    cur = 32'hA000_0006;
    for (int i = 0; i < 12; i++) step(cur, "R8");

    // R8: change reverts to the captured word before the walk ends
    capA = 32'h5555_AAAA;
    step(capA, "R3");
    step(32'h1111_1111, "R7");
    step(32'h2222_2222, "R7");
    for (int i = 0; i < 12; i++) step(capA, "R8");

    // Change only in the top slice, then only in the bottom slice
    step(capA ^ 32'h8000_0000, "R3");
    for (int i = 0; i < 9; i++) step(capA ^ 32'h8000_0000, "R4");
    step(capA ^ 32'h8000_0001, "R3");
    for (int i = 0; i < 9; i++) step(capA ^ 32'h8000_0001, "R4");

    // Random mix, including a mid-run reset
    cur = capA;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) cur = $urandom;
      if (i == 1500) begin
        @(negedge clk); rstN = 1'b0;
        step(cur, "R1");
        step(cur, "R1");
        @(negedge clk); rstN = 1'b1;
        lowRun = 0;
      end
      step(cur, "R6");
    end
    step(cur, "R6");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule